// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent page translations that sits in front of a page table walker. Every entry carries a virtual page number, a physical page number and the ID of the process that owns it. A lookup compares the incoming virtual page, together with the ID of the running process, against every entry. On a hit it returns the physical page in the same cycle, so the page table entry needs no extra memory read. On a miss it raises a request to the walker.

The walker answers with a fill. A fill that reports the page as present is installed under the running process ID. A fill that reports the page as absent installs nothing and raises a fault instead. Because the process ID is part of the tag, a context switch only reloads the current-process register and the buffer is not purged. Entries of other processes stay resident and simply miss. Software-driven flushes can clear the whole buffer or only the entries of one process.

Replacement approximates least-recently-used with one reference bit per entry. A hit or a fill sets the bit. When every bit is found set at replacement time, all bits are cleared together.

Top module: `ptag_xlate_buf`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and the current process ID reads 0.
- R2: When `lk_valid` is high and a valid entry holds `lk_vpn` under the current process ID, `lk_hit` is high and `lk_ppn` carries that entry's physical page in the same cycle.
- R3: `walk_req` equals `lk_valid` and not `lk_hit`. With `lk_valid` low, both `lk_hit` and `walk_req` are low.
- R4: An entry whose process ID differs from the current ID misses even when its virtual page matches. `pid_load` updates the current ID from the following cycle onward, and entries of the earlier ID remain resident.
- R5: A fill with `fill_present` high installs `fill_vpn`/`fill_ppn` under the current process ID. If that page and ID are already resident, the fill overwrites that entry in place, so no key is ever held twice.
- R6: A fill with `fill_present` low installs nothing, and `fault` is high in the cycle after it. `fault` is low otherwise.
- R7: A new translation goes to the lowest-numbered invalid entry when one exists, and no valid entry is displaced.
- R8: When all entries are valid, the victim is the lowest-numbered entry whose reference bit is 0. A hit and a fill each set the reference bit of the entry involved.
- R9: When all entries are valid and every reference bit is 1, all reference bits are cleared and entry 0 is the victim. A hit in the same cycle sets its bit again.
- R10: `flush_all` invalidates every entry at the next clock edge.
- R11: `flush_pid_en` invalidates only the entries whose process ID equals `flush_pid`, and leaves all others resident.
- R12: A fill in the same cycle as either flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_load | input | 1 | Load `pid_new` into the current process ID register |
| pid_new | input | PID_W | Process ID to load |
| pid_cur | output | PID_W | Current process ID |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a resident entry |
| lk_ppn | output | PPN_W | Physical page number on a hit, 0 otherwise |
| walk_req | output | 1 | Lookup missed; walker must resolve `lk_vpn` |
| fill_valid | input | 1 | Walker response this cycle |
| fill_present | input | 1 | Walked page is resident in memory |
| fill_vpn | input | VPN_W | Virtual page of the response |
| fill_ppn | input | PPN_W | Physical page of the response |
| fault | output | 1 | Registered page-absent indication |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | PID_W | Process ID selected for invalidation |

## Verification
The bench aims at the replacement corners. It checks the sweep case where every reference bit is set and entry 0 must be taken. A design that chose a later entry, or that forgot to clear the bits, would evict a different page than expected, and that page would miss later. It checks that the entry freed by a per-process flush is reused ahead of any valid entry. A victim selector that ignored validity would destroy a live translation. It checks context switches, where a design that dropped the process ID from the compare would return another process's physical page. Flushes that coincide with fills are also checked, because a design that let the fill through would leave an entry resident after the flush. A bench model runs next to the design under a seeded random mix of lookups, fills, absent pages, ID loads and flushes. It catches wrong victims through lookups that should or should not hit.

// File: rtl/ptxb_pkg.sv
`timescale 1ns/1ps
package ptxb_pkg;
   localparam int DEF_ENTRIES = 16;
   localparam int DEF_VPN_W   = 20;
   localparam int DEF_PPN_W   = 20;
   localparam int DEF_PID_W   = 8;

   // How the replacement slot was chosen
   typedef enum logic [1:0] {
      VK_FREE  = 2'd0,   // an invalid slot was available
      VK_UNREF = 2'd1,   // a valid slot with clear reference bit
      VK_SWEEP = 2'd2    // all referenced: clear bits, take slot 0
   } vkind_e;
endpackage

// File: rtl/ptxb_slot.sv
`timescale 1ns/1ps
module ptxb_slot #(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] q_vpn,
   input  logic [PID_W-1:0] q_pid,
   input  logic [VPN_W-1:0] w_vpn,
   input  logic [PPN_W-1:0] w_ppn,
   input  logic             w_en,
   input  logic             ref_clr,
   input  logic             ref_set,
   input  logic             flush_all,
   input  logic             flush_pid_en,
   input  logic [PID_W-1:0] flush_pid,
   output logic             valid_o,
   output logic             ref_o,
   output logic             q_match_o,
   output logic             w_match_o,
   output logic [PPN_W-1:0] ppn_o
);
   logic             valid_q;
   logic             ref_q;
   logic             ref_n;
   logic             kill;
   logic [VPN_W-1:0] vpn_q;
   logic [PID_W-1:0] pid_q;
   logic [PPN_W-1:0] ppn_q;

   assign kill      = flush_all | (flush_pid_en & valid_q & (pid_q == flush_pid));
   assign q_match_o = valid_q & (vpn_q == q_vpn) & (pid_q == q_pid);
   assign w_match_o = valid_q & (vpn_q == w_vpn) & (pid_q == q_pid);
   assign valid_o   = valid_q;
   assign ref_o     = ref_q;
   assign ppn_o     = ppn_q;

   always_comb begin
      ref_n = ref_clr ? 1'b0 : ref_q;
      if (ref_set || w_en) begin
         ref_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ref_q   <= 1'b0;
         vpn_q   <= '0;
         pid_q   <= '0;
         ppn_q   <= '0;
      end else begin
         ref_q <= ref_n;
         if (kill) begin
            valid_q <= 1'b0;
         end else if (w_en) begin
            valid_q <= 1'b1;
            vpn_q   <= w_vpn;
            pid_q   <= q_pid;
            ppn_q   <= w_ppn;
         end
      end
   end
endmodule

// File: rtl/ptxb_victim.sv
`timescale 1ns/1ps
module ptxb_victim
   import ptxb_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] ref_vec,
   output logic [ENTRIES-1:0] victim_oh,
   output vkind_e             kind
);
   logic [ENTRIES-1:0] free_oh;
   logic [ENTRIES-1:0] unref_oh;
   logic               free_any;
   logic               unref_any;

   always_comb begin
      free_oh   = '0;
      unref_oh  = '0;
      free_any  = 1'b0;
      unref_any = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid_vec[i] && !free_any) begin
            free_oh[i] = 1'b1;
            free_any   = 1'b1;
         end
         if (!ref_vec[i] && !unref_any) begin
            unref_oh[i] = 1'b1;
            unref_any   = 1'b1;
         end
      end
   end

   always_comb begin
      if (free_any) begin
         kind      = VK_FREE;
         victim_oh = free_oh;
      end else if (unref_any) begin
         kind      = VK_UNREF;
         victim_oh = unref_oh;
      end else begin
         kind      = VK_SWEEP;
         victim_oh = {{(ENTRIES-1){1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/ptxb_read_mux.sv
`timescale 1ns/1ps
module ptxb_read_mux #(
   parameter int ENTRIES     = 16,
   parameter int PPN_W       = 20,
   parameter bit ONEHOT_READ = 1'b1
) (
   input  logic [ENTRIES-1:0] hit_vec,
   input  logic [PPN_W-1:0]   ppn_arr [ENTRIES],
   output logic [PPN_W-1:0]   ppn_o
);
   generate
      if (ONEHOT_READ) begin : g_andor
         // relies on at most one hit: flat AND-OR, shallow depth
         always_comb begin
            ppn_o = '0;
            for (int i = 0; i < ENTRIES; i++) begin
               ppn_o = ppn_o | (ppn_arr[i] & {PPN_W{hit_vec[i]}});
            end
         end
      end else begin : g_prio
         // lowest index wins; tolerant of multiple hits
         always_comb begin
            ppn_o = '0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
               if (hit_vec[i]) begin
                  ppn_o = ppn_arr[i];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ptag_xlate_buf.sv
`timescale 1ns/1ps
module ptag_xlate_buf
   import ptxb_pkg::*;
#(
   parameter int ENTRIES     = DEF_ENTRIES,
   parameter int VPN_W       = DEF_VPN_W,
   parameter int PPN_W       = DEF_PPN_W,
   parameter int PID_W       = DEF_PID_W,
   parameter bit ONEHOT_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pid_load,
   input  logic [PID_W-1:0] pid_new,
   output logic [PID_W-1:0] pid_cur,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             walk_req,
   input  logic             fill_valid,
   input  logic             fill_present,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   output logic             fault,
   input  logic             flush_all,
   input  logic             flush_pid_en,
   input  logic [PID_W-1:0] flush_pid
);
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("ptag_xlate_buf: ENTRIES must be at least 2");
      end
      if (VPN_W < 1 || PPN_W < 1 || PID_W < 1) begin : g_bad_width
         $error("ptag_xlate_buf: field widths must be positive");
      end
   endgenerate

   logic [PID_W-1:0]   pid_q;
   logic               fault_q;
   logic [ENTRIES-1:0] q_match;
   logic [ENTRIES-1:0] w_match;
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] ref_vec;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] victim_oh;
   logic [ENTRIES-1:0] wr_sel;
   logic [PPN_W-1:0]   ppn_arr [ENTRIES];
   vkind_e             vkind;
   logic               flushing;
   logic               install;
   logic               refill;
   logic               sweep;

   assign hit_vec  = q_match & {ENTRIES{lk_valid}};
   assign lk_hit   = |hit_vec;
   assign walk_req = lk_valid & ~lk_hit;
   assign flushing = flush_all | flush_pid_en;
   assign install  = fill_valid & fill_present & ~flushing;
   assign refill   = |w_match;
   assign wr_sel   = refill ? w_match : victim_oh;
   assign sweep    = install & ~refill & (vkind == VK_SWEEP);
   assign pid_cur  = pid_q;
   assign fault    = fault_q;

   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
         ptxb_slot #(
            .VPN_W (VPN_W),
            .PPN_W (PPN_W),
            .PID_W (PID_W)
         ) slot_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .q_vpn        (lk_vpn),
            .q_pid        (pid_q),
            .w_vpn        (fill_vpn),
            .w_ppn        (fill_ppn),
            .w_en         (install & wr_sel[gi]),
            .ref_clr      (sweep),
            .ref_set      (hit_vec[gi]),
            .flush_all    (flush_all),
            .flush_pid_en (flush_pid_en),
            .flush_pid    (flush_pid),
            .valid_o      (valid_vec[gi]),
            .ref_o        (ref_vec[gi]),
            .q_match_o    (q_match[gi]),
            .w_match_o    (w_match[gi]),
            .ppn_o        (ppn_arr[gi])
         );
      end
   endgenerate

   ptxb_victim #(
      .ENTRIES (ENTRIES)
   ) victim_i (
      .valid_vec (valid_vec),
      .ref_vec   (ref_vec),
      .victim_oh (victim_oh),
      .kind      (vkind)
   );

   ptxb_read_mux #(
      .ENTRIES     (ENTRIES),
      .PPN_W       (PPN_W),
      .ONEHOT_READ (ONEHOT_READ)
   ) rmux_i (
      .hit_vec (hit_vec),
      .ppn_arr (ppn_arr),
      .ppn_o   (lk_ppn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pid_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fill_valid & ~fill_present;
         if (pid_load) begin
            pid_q <= pid_new;
         end
      end
   end
endmodule

// File: rtl/ptxb_chk.sv
`timescale 1ns/1ps
module ptxb_chk #(
   parameter int ENTRIES = 16,
   parameter int PID_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_hit,
   input logic               walk_req,
   input logic [ENTRIES-1:0] hit_vec,
   input logic               fill_valid,
   input logic               fill_present,
   input logic               fault,
   input logic               flush_all,
   input logic               pid_load,
   input logic [PID_W-1:0]   pid_new,
   input logic [PID_W-1:0]   pid_cur
);
   // R2
   hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);

   // R3
   walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (walk_req != lk_hit));

   // R5
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R6
   fault_after_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !fill_present) |=> fault);

   // R10
   flush_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !lk_hit);

   // R4
   pid_load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pid_load |=> (pid_cur == $past(pid_new)));
endmodule

bind ptag_xlate_buf ptxb_chk #(
   .ENTRIES (ENTRIES),
   .PID_W   (PID_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_hit       (lk_hit),
   .walk_req     (walk_req),
   .hit_vec      (hit_vec),
   .fill_valid   (fill_valid),
   .fill_present (fill_present),
   .fault        (fault),
   .flush_all    (flush_all),
   .pid_load     (pid_load),
   .pid_new      (pid_new),
   .pid_cur      (pid_cur)
);

// File: tb/ptag_xlate_buf_tb_top.sv
`timescale 1ns/1ps
module ptag_xlate_buf_tb_top;
   localparam int N  = 16;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pid_load = 1'b0;
   logic [DW-1:0] pid_new = '0;
   logic [DW-1:0] pid_cur;
   logic          lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_hit;
   logic [PW-1:0] lk_ppn;
   logic          walk_req;
   logic          fill_valid = 1'b0;
   logic          fill_present = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [PW-1:0] fill_ppn = '0;
   logic          fault;
   logic          flush_all = 1'b0;
   logic          flush_pid_en = 1'b0;
   logic [DW-1:0] flush_pid = '0;

   int checks = 0;
   int errors = 0;

   // bench model
   logic          m_v   [N];
   logic          m_ref [N];
   logic [VW-1:0] m_vpn [N];
   logic [DW-1:0] m_pid [N];
   logic [PW-1:0] m_ppn [N];
   logic [DW-1:0] m_cur;
   logic          m_fault;

   always #2 clk = ~clk;   // 250 MHz

   ptag_xlate_buf dut_i (
      .clk (clk), .rst_n (rst_n),
      .pid_load (pid_load), .pid_new (pid_new), .pid_cur (pid_cur),
      .lk_valid (lk_valid), .lk_vpn (lk_vpn), .lk_hit (lk_hit),
      .lk_ppn (lk_ppn), .walk_req (walk_req),
      .fill_valid (fill_valid), .fill_present (fill_present),
      .fill_vpn (fill_vpn), .fill_ppn (fill_ppn), .fault (fault),
      .flush_all (flush_all), .flush_pid_en (flush_pid_en), .flush_pid (flush_pid)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int m_find(input logic [VW-1:0] vpn, input logic [DW-1:0] pid);
      for (int i = 0; i < N; i++) begin
         if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
      end
      return -1;
   endfunction

   function automatic bit m_other_pid(input logic [VW-1:0] vpn);
      for (int i = 0; i < N; i++) begin
         if (m_v[i] && m_vpn[i] == vpn && m_pid[i] != m_cur) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic int m_victim(output bit sweep);
      sweep = 1'b0;
      for (int i = 0; i < N; i++) if (!m_v[i]) return i;     // R7
      for (int i = 0; i < N; i++) if (!m_ref[i]) return i;   // R8
      sweep = 1'b1;                                          // R9
      return 0;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin
         m_v[i] = 1'b0; m_ref[i] = 1'b0;
         m_vpn[i] = '0; m_pid[i] = '0; m_ppn[i] = '0;
      end
      m_cur = '0;
      m_fault = 1'b0;
   endtask

   task automatic m_step();
      int  h;
      int  w;
      bit  sw;
      h = lk_valid ? m_find(lk_vpn, m_cur) : -1;
      if (flush_all) begin
         for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      end else if (flush_pid_en) begin
         for (int i = 0; i < N; i++) if (m_pid[i] == flush_pid) m_v[i] = 1'b0;
      end else if (fill_valid && fill_present) begin
         w = m_find(fill_vpn, m_cur);
         sw = 1'b0;
         if (w < 0) w = m_victim(sw);
         if (sw) for (int i = 0; i < N; i++) m_ref[i] = 1'b0;
         m_v[w] = 1'b1; m_vpn[w] = fill_vpn; m_pid[w] = m_cur;
         m_ppn[w] = fill_ppn; m_ref[w] = 1'b1;
      end
      if (h >= 0) m_ref[h] = 1'b1;
      m_fault = fill_valid && !fill_present;
      if (pid_load) m_cur = pid_new;
   endtask

   task automatic idle();
      pid_load = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0; fill_present = 1'b0;
      flush_all = 1'b0; flush_pid_en = 1'b0;
   endtask

   // inputs already driven after a falling edge; compare, then advance
   task automatic cyc(input string tag);
      int    e;
      string t;
      #1;
      e = lk_valid ? m_find(lk_vpn, m_cur) : -1;
      t = tag;
      if (t == "") t = (e >= 0) ? "R2" : (lk_valid && m_other_pid(lk_vpn)) ? "R4" : "R3";
      check(lk_hit == (e >= 0), t, "lk_hit", lk_hit, (e >= 0));
      if (e >= 0) check(lk_ppn == m_ppn[e], t, "lk_ppn", lk_ppn, m_ppn[e]);
      check(walk_req == (lk_valid && e < 0), "R3", "walk_req", walk_req, (lk_valid && e < 0));
      check(fault == m_fault, "R6", "fault", fault, m_fault);
      check(pid_cur == m_cur, "R4", "pid_cur", pid_cur, m_cur);
      @(posedge clk);
      m_step();
      @(negedge clk);
      idle();
   endtask

   task automatic look(input int vpn, input string tag);
      lk_valid = 1'b1; lk_vpn = VW'(vpn);
      cyc(tag);
   endtask

   task automatic fill(input int vpn, input int ppn, input bit present, input string tag);
      fill_valid = 1'b1; fill_present = present;
      fill_vpn = VW'(vpn); fill_ppn = PW'(ppn);
      cyc(tag);
   endtask

   task automatic setpid(input int p);
      pid_load = 1'b1; pid_new = DW'(p);
      cyc("R4");
   endtask

   initial begin
      #800000;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      m_reset();
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset, ID 0
      look(5, "R1");
      look(0, "R1");
      // R5 install, R2 hit
      fill(5, 'h123, 1'b1, "R5");
      look(5, "R2");
      fill(5, 'h124, 1'b1, "R5");   // overwrite in place
      look(5, "R5");
      // R4 context switch
      setpid(2);
      look(5, "R4");
      fill(5, 'h77, 1'b1, "R4");
      look(5, "R4");
      setpid(0);
      look(5, "R4");
      // R6 absent page
      fill(9, 'h55, 1'b0, "R6");
      look(9, "R6");
      // R10
      flush_all = 1'b1; cyc("R10");
      look(5, "R10");
      // R7 / R11: one pid-3 entry in slot 0, pid 0 fills the rest
      setpid(3);
      fill(9, 'h900, 1'b1, "R7");
      setpid(0);
      for (int v = 0; v < 15; v++) fill(v, 'h400 + v, 1'b1, "R7");
      flush_pid_en = 1'b1; flush_pid = 8'd3; cyc("R11");
      for (int v = 0; v < 15; v++) look(v, "R11");
      fill(30, 'h430, 1'b1, "R7");  // reuses freed slot
      for (int v = 0; v < 15; v++) look(v, "R7");
      look(30, "R7");
      // R9: all referenced -> slot 0 (vpn 30) replaced
      fill(31, 'h431, 1'b1, "R9");
      look(30, "R9");
      look(31, "R9");
      look(0, "R9");
      // R8: first clear bit now at slot 2 (vpn 1)
      fill(32, 'h432, 1'b1, "R8");
      look(1, "R8");
      look(2, "R8");
      look(32, "R8");
      // R12: flushes beat a concurrent fill
      flush_pid_en = 1'b1; flush_pid = 8'd7;
      fill(40, 'h440, 1'b1, "R12");
      look(40, "R12");
      flush_all = 1'b1;
      fill(41, 'h441, 1'b1, "R12");
      look(41, "R12");
      look(3, "R12");
      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         lk_valid = ($urandom % 10) < 7;
         lk_vpn   = VW'($urandom % 12);
         fill_valid   = ($urandom % 10) < 4;
         fill_present = ($urandom % 100) < 85;
         fill_vpn     = VW'($urandom % 12);
         fill_ppn     = PW'($urandom);
         pid_load = ($urandom % 100) < 5;
         pid_new  = DW'($urandom % 4);
         flush_all    = ($urandom % 100) < 1;
         flush_pid_en = ($urandom % 100) < 3;
         flush_pid    = DW'($urandom % 4);
         cyc("");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule